// File: doc/BRIEF.md
# Fuse Configuration Store with Readback Lock

This block keeps the configuration image of a small programmable logic device in plain registers. The image has two regions. The functional region sets up the logic array. The user region is a 64-bit signature that holds things such as an identifier, a revision code or an inventory tag. Every bit sits at one linear bit address, and a single-cycle command port works on that address space. The commands are: start a programming cycle, write one bit, write one aligned word, read one aligned word, and set the readback lock.

A programming cycle always begins with an erase sweep. The sweep returns every bit to 1, which is the intact-fuse state. It runs one word per clock while `busy` is high, and every command issued during the sweep is dropped. The lock bit hides the functional region from readback, so those reads return zero and raise a blocked flag. Signature reads work whether the lock is set or not. Only a completed erase sweep clears the lock, and that sweep also wipes the configuration. The functional bits are driven at all times on a wide parallel output for the logic array, and the lock has no effect on that output. An image that covers only the functional region is a valid image: the signature keeps its erased value.

Top module: `fuse_cfg_store`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `locked` and `rd_valid` are 0 and every bit of `cfg_bits` is 1.
- R2: A bit-write command (`cmd_op` = 2) stores `cmd_wdata[0]` at bit address `cmd_addr`. The new value appears on `cfg_bits` in the cycle after the command.
- R3: A word-write command (`cmd_op` = 3) stores `cmd_wdata` at the word whose base is `cmd_addr` rounded down to a multiple of WORD_W. Bit j of the data goes to address base+j.
- R4: A read command (`cmd_op` = 4) raises `rd_valid` for exactly one cycle, the cycle after the command. In that cycle `rd_data` bit j holds the bit at address base+j, where base is the aligned word base.
- R5: A lock command (`cmd_op` = 5) sets `locked` in the next cycle. From then on, every read of a functional address (below FUNC_BITS = 5828) returns zero with `rd_blocked` = 1. `cfg_bits` is not affected.
- R6: A read of a signature address (5828 to 5891) returns the stored data with `rd_blocked` = 0, whatever the state of the lock.
- R7: A programming-start command (`cmd_op` = 1) holds `busy` high from the next cycle for exactly TOTAL_BITS/WORD_W (1473) cycles. After that, every bit, signature included, reads 1 and `locked` is 0.
- R8: Once set, the lock stays set through any writes, reads and lock commands. Only the end of an erase sweep clears it. Writes still reach the store while the lock is set.
- R9: Any command issued while `busy` is high is ignored. It writes nothing and produces no `rd_valid`.
- R10: Writes to addresses at or above 5892 change nothing. A read of such an address returns zero with `rd_blocked` = 0.
- R11: An image that writes only the functional words after a programming start leaves every signature bit at 1.
- R12: The store does not change in a cycle where `cmd_valid` is 0 or `cmd_op` is 0, 6 or 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | 1 program-start, 2 bit write, 3 word write, 4 read, 5 lock; other values idle |
| cmd_addr | input | 13 | Bit address (word commands ignore the low log2(WORD_W) bits) |
| cmd_wdata | input | WORD_W (4) | Write data; a bit write uses bit 0 |
| busy | output | 1 | Erase sweep in progress |
| locked | output | 1 | Readback lock state |
| rd_valid | output | 1 | Read result present |
| rd_data | output | WORD_W (4) | Read result |
| rd_blocked | output | 1 | Read result suppressed by the lock |
| cfg_bits | output | FUNC_BITS (5828) | Functional configuration driven to the logic array |

## Verification
The embedded properties check the following on every cycle. Read results appear only one cycle after an accepted read, and none while the sweep runs. A blocked result needs the lock to have been set, and signature reads are never blocked. The lock falls only at the end of a sweep. The sweep pointer stays in range and finishes on the last word. The store is untouched in idle cycles. Other behaviour can only be shown by the scenarios, which run against a behavioural model. These include the exact bit placement of bit and word writes, the stored values that come back from reads, the full erased image after a sweep, and writes dropped during the sweep or outside the address space. They also include a functional-only image leaving the signature erased.

// File: rtl/fuse_pkg.sv
// Shared command and address-region encodings for the fuse configuration store.
package fuse_pkg;

    // Command codes carried on cmd_op
    typedef enum logic [2:0] {
        OP_IDLE  = 3'd0,
        OP_PROG  = 3'd1,
        OP_WBIT  = 3'd2,
        OP_WWORD = 3'd3,
        OP_READ  = 3'd4,
        OP_LOCK  = 3'd5
    } fuse_op_e;

    // Which part of the address space a command targets
    typedef enum logic [1:0] {
        RGN_FUNC = 2'd0,
        RGN_SIG  = 2'd1,
        RGN_NONE = 2'd2
    } fuse_rgn_e;

endpackage

// File: rtl/fuse_cmd_decode.sv
// Command decoder: turns one command into single-cycle action strobes.
// Assumes WORD_W is a power of two, and that FUNC_BITS and TOTAL_BITS are
// multiples of WORD_W, so no word straddles the region boundary.
// Every action is suppressed while the erase sweep is running. Writes to
// addresses outside the map are dropped; reads there still respond.
module fuse_cmd_decode
    import fuse_pkg::*;
#(
    parameter int FUNC_BITS  = 5828,
    parameter int TOTAL_BITS = 5892,
    parameter int ADDR_W     = 13,
    parameter int WIDX_W     = 11
) (
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              busy_i,
    output logic              prog_o,
    output logic              wbit_o,
    output logic              wword_o,
    output logic              read_o,
    output logic              lock_o,
    output fuse_rgn_e         rgn_o,
    output logic [WIDX_W-1:0] widx_o
);

    localparam int OFF_W = ADDR_W - WIDX_W;

    logic accept;
    logic in_map;

    // Region classification of the bit address
    always_comb begin
        if (cmd_addr < ADDR_W'(FUNC_BITS)) begin
            rgn_o = RGN_FUNC;
        end else if (cmd_addr < ADDR_W'(TOTAL_BITS)) begin
            rgn_o = RGN_SIG;
        end else begin
            rgn_o = RGN_NONE;
        end
    end

    assign in_map = (rgn_o != RGN_NONE);
    assign accept = cmd_valid && !busy_i;
    assign widx_o = cmd_addr[ADDR_W-1:OFF_W];

    // Action strobes; unknown codes fall through to no action
    always_comb begin
        prog_o  = 1'b0;
        wbit_o  = 1'b0;
        wword_o = 1'b0;
        read_o  = 1'b0;
        lock_o  = 1'b0;
        if (accept) begin
            case (cmd_op)
                OP_PROG:  prog_o  = 1'b1;
                OP_WBIT:  wbit_o  = in_map;
                OP_WWORD: wword_o = in_map;
                OP_READ:  read_o  = 1'b1;
                OP_LOCK:  lock_o  = 1'b1;
                default:  ;
            endcase
        end
    end

endmodule

// File: rtl/fuse_erase_seq.sv
// Erase sweep sequencer: on start, walks a word pointer across the whole map
// for one word per cycle, holding busy high until the last word is done.
// Assumes start is never asserted while busy (the decoder gates it).
module fuse_erase_seq #(
    parameter int NWORDS = 1473,
    parameter int WIDX_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    output logic              busy_o,
    output logic [WIDX_W-1:0] ptr_o,
    output logic              last_o
);

    localparam logic [WIDX_W-1:0] LAST_IDX = WIDX_W'(NWORDS - 1);

    assign last_o = busy_o && (ptr_o == LAST_IDX);

    // Sweep state: idle -> walking -> idle after the final word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_o <= 1'b0;
            ptr_o  <= '0;
        end else if (busy_o) begin
            if (ptr_o == LAST_IDX) begin
                busy_o <= 1'b0;
                ptr_o  <= '0;
            end else begin
                ptr_o <= ptr_o + 1'b1;
            end
        end else if (start_i) begin
            busy_o <= 1'b1;
            ptr_o  <= '0;
        end
    end

    AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> ptr_o <= LAST_IDX); // R7

    AST_SWEEP_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $fell(busy_o) |-> $past(ptr_o) == LAST_IDX); // R7

endmodule

// File: rtl/fuse_array.sv
// Storage for the whole map as one flat vector of bits. It applies erase,
// word writes and bit writes, presents one word for readback, and drives the
// functional part in parallel. Erase has priority; the decoder keeps the
// write strobes low during a sweep. Reset loads the erased image (all ones).
module fuse_array #(
    parameter int FUNC_BITS  = 5828,
    parameter int TOTAL_BITS = 5892,
    parameter int WORD_W     = 4,
    parameter int ADDR_W     = 13,
    parameter int WIDX_W     = 11
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 erase_en,
    input  logic [WIDX_W-1:0]    erase_idx,
    input  logic                 wbit_en,
    input  logic                 wword_en,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic [WIDX_W-1:0]    widx_i,
    input  logic [WORD_W-1:0]    wdata_i,
    output logic [WORD_W-1:0]    rd_word_o,
    output logic [FUNC_BITS-1:0] cfg_o
);

    localparam int OFF_W = ADDR_W - WIDX_W;

    logic [TOTAL_BITS-1:0] mem_q;
    logic [ADDR_W-1:0]     erase_base;
    logic [ADDR_W-1:0]     word_base;

    assign erase_base = {erase_idx, {OFF_W{1'b0}}};
    assign word_base  = {widx_i, {OFF_W{1'b0}}};

    // Fuse state update: erase word, word write, or single-bit write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_q <= '1;
        end else if (erase_en) begin
            mem_q[erase_base +: WORD_W] <= '1;
        end else if (wword_en) begin
            mem_q[word_base +: WORD_W] <= wdata_i;
        end else if (wbit_en) begin
            mem_q[addr_i] <= wdata_i[0];
        end
    end

    // Readback word and parallel configuration outputs
    assign rd_word_o = mem_q[word_base +: WORD_W];
    assign cfg_o     = mem_q[FUNC_BITS-1:0];

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(erase_en || wword_en || wbit_en) |-> $stable(mem_q)); // R12

endmodule

// File: rtl/fuse_read_guard.sv
// Readback stage: registers the result of a read. It zeroes functional data
// while the lock is set, and zeroes addresses outside the map. The signature
// region always passes. rd_data and rd_blocked hold between reads.
module fuse_read_guard
    import fuse_pkg::*;
#(
    parameter int WORD_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req_i,
    input  fuse_rgn_e         rgn_i,
    input  logic              locked_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              rd_valid_o,
    output logic [WORD_W-1:0] rd_data_o,
    output logic              rd_blocked_o
);

    logic hide;

    assign hide = (rgn_i == RGN_FUNC) && locked_i;

    // Result register with lock masking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid_o   <= 1'b0;
            rd_data_o    <= '0;
            rd_blocked_o <= 1'b0;
        end else begin
            rd_valid_o <= rd_req_i;
            if (rd_req_i) begin
                rd_blocked_o <= hide;
                rd_data_o    <= (hide || rgn_i == RGN_NONE) ? '0 : word_i;
            end
        end
    end

    AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && rd_valid_o |-> $past(rd_req_i)); // R4

    AST_BLOCK_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && rd_valid_o && rd_blocked_o |-> $past(locked_i)); // R5

    AST_SIG_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && rd_valid_o && $past(rgn_i) == RGN_SIG |-> !rd_blocked_o); // R6

endmodule

// File: rtl/fuse_lock_ctl.sv
// Readback lock bit: set by a lock command and cleared only by the final
// step of an erase sweep. Assumes set and clear never coincide, because
// commands are gated off while the sweep runs.
module fuse_lock_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic locked_o
);

    // Lock state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked_o <= 1'b0;
        end else if (clr_i) begin
            locked_o <= 1'b0;
        end else if (set_i) begin
            locked_o <= 1'b1;
        end
    end

endmodule

// File: rtl/fuse_cfg_store.sv
// Fuse configuration store top. It joins the command decoder, the erase
// sequencer, the fuse array, the lock bit and the read guard. Addresses are
// bit addresses: functional bits first, then the signature bits. Assumes
// WORD_W is a power of two of at least 2 that divides both regions.
module fuse_cfg_store
    import fuse_pkg::*;
#(
    parameter int  FUNC_BITS  = 5828,
    parameter int  SIG_BITS   = 64,
    parameter int  WORD_W     = 4,
    localparam int TOTAL_BITS = FUNC_BITS + SIG_BITS,
    localparam int ADDR_W     = $clog2(TOTAL_BITS),
    localparam int OFF_W      = $clog2(WORD_W),
    localparam int WIDX_W     = ADDR_W - OFF_W,
    localparam int NWORDS     = TOTAL_BITS / WORD_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    input  logic [2:0]           cmd_op,
    input  logic [ADDR_W-1:0]    cmd_addr,
    input  logic [WORD_W-1:0]    cmd_wdata,
    output logic                 busy,
    output logic                 locked,
    output logic                 rd_valid,
    output logic [WORD_W-1:0]    rd_data,
    output logic                 rd_blocked,
    output logic [FUNC_BITS-1:0] cfg_bits
);

    logic              do_prog;
    logic              do_wbit;
    logic              do_wword;
    logic              do_read;
    logic              do_lock;
    fuse_rgn_e         rgn;
    logic [WIDX_W-1:0] widx;
    logic [WIDX_W-1:0] sweep_ptr;
    logic              sweep_last;
    logic [WORD_W-1:0] rd_word;

    fuse_cmd_decode #(
        .FUNC_BITS  (FUNC_BITS),
        .TOTAL_BITS (TOTAL_BITS),
        .ADDR_W     (ADDR_W),
        .WIDX_W     (WIDX_W)
    ) u_dec (
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_addr  (cmd_addr),
        .busy_i    (busy),
        .prog_o    (do_prog),
        .wbit_o    (do_wbit),
        .wword_o   (do_wword),
        .read_o    (do_read),
        .lock_o    (do_lock),
        .rgn_o     (rgn),
        .widx_o    (widx)
    );

    fuse_erase_seq #(
        .NWORDS (NWORDS),
        .WIDX_W (WIDX_W)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (do_prog),
        .busy_o  (busy),
        .ptr_o   (sweep_ptr),
        .last_o  (sweep_last)
    );

    fuse_array #(
        .FUNC_BITS  (FUNC_BITS),
        .TOTAL_BITS (TOTAL_BITS),
        .WORD_W     (WORD_W),
        .ADDR_W     (ADDR_W),
        .WIDX_W     (WIDX_W)
    ) u_arr (
        .clk       (clk),
        .rst_n     (rst_n),
        .erase_en  (busy),
        .erase_idx (sweep_ptr),
        .wbit_en   (do_wbit),
        .wword_en  (do_wword),
        .addr_i    (cmd_addr),
        .widx_i    (widx),
        .wdata_i   (cmd_wdata),
        .rd_word_o (rd_word),
        .cfg_o     (cfg_bits)
    );

    fuse_lock_ctl u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (do_lock),
        .clr_i    (sweep_last),
        .locked_o (locked)
    );

    fuse_read_guard #(
        .WORD_W (WORD_W)
    ) u_rdg (
        .clk          (clk),
        .rst_n        (rst_n),
        .rd_req_i     (do_read),
        .rgn_i        (rgn),
        .locked_i     (locked),
        .word_i       (rd_word),
        .rd_valid_o   (rd_valid),
        .rd_data_o    (rd_data),
        .rd_blocked_o (rd_blocked)
    );

    AST_LOCK_ONLY_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $fell(locked) |-> $past(busy) && !busy); // R8

    AST_BUSY_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(busy) |-> !rd_valid); // R9

endmodule

// File: tb/sim_fuse_cfg_store.sv
// Bench: a behavioural reference model updated on every rising edge and
// compared with the outputs on every falling edge, plus directed scenarios.
module sim_fuse_cfg_store;

    localparam int CLK_PERIOD = 10;
    localparam int FUNC  = 5828;
    localparam int SIG   = 64;
    localparam int W     = 4;
    localparam int TOTAL = FUNC + SIG;
    localparam int AW    = 13;
    localparam int NW    = TOTAL / W;
    localparam int LIMIT = 100000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [2:0]    cmd_op = 3'd0;
    logic [AW-1:0] cmd_addr = '0;
    logic [W-1:0]  cmd_wdata = '0;
    logic          busy;
    logic          locked;
    logic          rd_valid;
    logic [W-1:0]  rd_data;
    logic          rd_blocked;
    logic [FUNC-1:0] cfg_bits;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit finished = 1'b0;

    // reference model state
    bit [TOTAL-1:0] m_mem;
    bit             m_lock;
    int             m_left;
    bit             m_rv;
    bit [W-1:0]     m_rd;
    bit             m_blk;

    always #(CLK_PERIOD/2) clk = ~clk;

    fuse_cfg_store u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_op     (cmd_op),
        .cmd_addr   (cmd_addr),
        .cmd_wdata  (cmd_wdata),
        .busy       (busy),
        .locked     (locked),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data),
        .rd_blocked (rd_blocked),
        .cfg_bits   (cfg_bits)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // behavioural model of the command set
    always @(posedge clk) begin
        if (!rst_n) begin
            m_mem = '1; m_lock = 0; m_left = 0; m_rv = 0; m_rd = '0; m_blk = 0;
        end else begin
            int a;
            int base;
            a = int'(cmd_addr);
            base = (a / W) * W;
            m_rv = 0;
            if (m_left > 0) begin
                m_left--;
                if (m_left == 0) begin
                    m_mem = '1;
                    m_lock = 0;
                end
            end else if (cmd_valid) begin
                case (cmd_op)
                    3'd1: m_left = NW;
                    3'd2: if (a < TOTAL) m_mem[a] = cmd_wdata[0];
                    3'd3: if (a < TOTAL) for (int j = 0; j < W; j++) m_mem[base + j] = cmd_wdata[j];
                    3'd4: begin
                        m_rv = 1;
                        if (a >= TOTAL) begin
                            m_rd = '0; m_blk = 0;
                        end else if (a < FUNC && m_lock) begin
                            m_rd = '0; m_blk = 1;
                        end else begin
                            for (int j = 0; j < W; j++) m_rd[j] = m_mem[base + j];
                            m_blk = 0;
                        end
                    end
                    3'd5: m_lock = 1;
                    default: ;
                endcase
            end
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(busy == (m_left > 0), "R7", "busy", busy, m_left > 0);
            chk(locked == m_lock, "R8", "locked", locked, m_lock);
            chk(rd_valid == m_rv, "R4", "rd_valid", rd_valid, m_rv);
            if (m_rv) begin
                chk(rd_data == m_rd, "R4", "rd_data", rd_data, m_rd);
                chk(rd_blocked == m_blk, "R5", "rd_blocked", rd_blocked, m_blk);
            end
            if (m_left == 0)
                chk(cfg_bits == m_mem[FUNC-1:0], "R2", "cfg mismatch bits",
                    $countones(cfg_bits ^ m_mem[FUNC-1:0]), 0);
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles == LIMIT && !finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog cycles actual=%0d expected<%0d", cycles, LIMIT);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic issue(input int op, input int a, input int d);
        cmd_valid = 1'b1;
        cmd_op    = 3'(op);
        cmd_addr  = AW'(a);
        cmd_wdata = W'(d);
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_op    = 3'd0;
    endtask

    task automatic read_chk(input int a, input int exp_d, input bit exp_b, input string req);
        issue(4, a, 0);
        chk(rd_valid == 1'b1, req, "read valid", rd_valid, 1);
        chk(rd_data == W'(exp_d), req, "read data", rd_data, exp_d);
        chk(rd_blocked == exp_b, req, "read blocked", rd_blocked, exp_b);
    endtask

    initial begin
        int n;
        int lfsr;
        repeat (5) @(negedge clk);
        // R1 reset state
        chk(busy == 0, "R1", "busy", busy, 0);
        chk(locked == 0, "R1", "locked", locked, 0);
        chk(rd_valid == 0, "R1", "rd_valid", rd_valid, 0);
        chk($countones(~cfg_bits) == 0, "R1", "zero bits", $countones(~cfg_bits), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 bit writes
        issue(2, 0, 0);
        issue(2, 5827, 0);
        chk(cfg_bits[0] == 0, "R2", "bit0", cfg_bits[0], 0);
        chk(cfg_bits[5827] == 0, "R2", "bit5827", cfg_bits[5827], 0);
        issue(2, 0, 1);
        chk(cfg_bits[0] == 1, "R2", "bit0 rewrite", cfg_bits[0], 1);

        // R3 word write, aligned down; R4 read
        issue(3, 9, 'hA);
        chk(cfg_bits[11:8] == 4'hA, "R3", "word at 8", cfg_bits[11:8], 'hA);
        read_chk(10, 'hA, 0, "R4");
        @(negedge clk);
        chk(rd_valid == 0, "R4", "single pulse", rd_valid, 0);

        // signature data
        issue(3, 5828, 5);
        issue(3, 5891, 'hC);
        read_chk(5829, 5, 0, "R6");
        read_chk(5888, 'hC, 0, "R6");

        // R10 out of range
        issue(3, 6000, 0);
        issue(2, 8191, 0);
        read_chk(6000, 0, 0, "R10");

        // R12 idle codes and cmd_valid low
        cmd_op = 3'd3; cmd_addr = AW'(8); cmd_wdata = '0;
        @(negedge clk);
        cmd_op = 3'd0;
        issue(0, 8, 0);
        issue(6, 8, 0);
        issue(7, 8, 0);
        read_chk(8, 'hA, 0, "R12");

        // R5 lock
        issue(5, 0, 0);
        chk(locked == 1, "R5", "locked", locked, 1);
        read_chk(8, 0, 1, "R5");
        read_chk(5827, 0, 1, "R5");
        chk(cfg_bits[11:8] == 4'hA, "R5", "cfg unaffected", cfg_bits[11:8], 'hA);
        // R6 signature open while locked
        read_chk(5828, 5, 0, "R6");
        read_chk(5891, 'hC, 0, "R6");

        // R8 lock sticky, writes land
        issue(3, 8, 3);
        issue(2, 100, 0);
        issue(5, 0, 0);
        issue(4, 5828, 0);
        chk(locked == 1, "R8", "still locked", locked, 1);
        chk(cfg_bits[11:8] == 4'h3, "R8", "write while locked", cfg_bits[11:8], 3);
        read_chk(8, 0, 1, "R8");

        // R7 erase sweep length and result
        issue(1, 0, 0);
        n = 0;
        while (busy) begin
            n++;
            @(negedge clk);
        end
        chk(n == NW, "R7", "busy cycles", n, NW);
        chk(locked == 0, "R7", "unlocked", locked, 0);
        chk($countones(~cfg_bits) == 0, "R7", "zero bits", $countones(~cfg_bits), 0);
        read_chk(5828, 'hF, 0, "R7");
        read_chk(5888, 'hF, 0, "R7");

        // R9 commands during sweep are dropped
        issue(2, 100, 0);
        issue(1, 0, 0);
        issue(2, 0, 0);
        issue(4, 5828, 0);
        chk(rd_valid == 0, "R9", "read during busy", rd_valid, 0);
        issue(5, 0, 0);
        while (busy) @(negedge clk);
        chk(cfg_bits[0] == 1, "R9", "write during busy", cfg_bits[0], 1);
        chk(locked == 0, "R9", "lock during busy", locked, 0);

        // R11 functional-only image
        for (int i = 0; i < FUNC / W; i++) issue(3, i * W, (i * 7 + 3) & 15);
        chk(cfg_bits[3:0] == 4'h3, "R11", "first word", cfg_bits[3:0], 3);
        for (int k = 0; k < SIG / W; k++) read_chk(FUNC + k * W, 'hF, 0, "R11");

        // mixed traffic against the model
        lfsr = 32'h1234;
        for (int i = 0; i < 400; i++) begin
            int op;
            lfsr = (lfsr * 1103515245 + 12345) & 32'h7fffffff;
            op = (lfsr >> 8) % 6;
            if (op == 1 || (op == 5 && (i % 7) != 0)) op = 4;
            issue(op, (lfsr >> 4) % 5950, lfsr & 15);
        end
        issue(1, 0, 0);
        while (busy) @(negedge clk);
        chk(locked == 0, "R7", "final unlock", locked, 0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule